// File: doc/BRIEF.md
# Bus Fail-Safe Receive Controller

This block conditions the receive path between a bus transceiver and the protocol controller. Each clock cycle it takes the raw received bit, a digital flag saying the bus input cannot be trusted (open line, stuck level or out-of-window input), and a request for silent operation. While the input is trusted, the raw bit passes straight to the controller. Once the flag has persisted long enough, the block pins the conditioned receive output to the recessive level.

The block has four states: normal, silent, fault-detected and fail-safe output. Two windows set when it moves. An invalid run shorter than the glitch window `GLITCH_Z` is ignored. An invalid run must last the persistence window `PERSIST_Y` before fail-safe output is entered. Valid input must be stable for `PERSIST_Y` cycles before the block leaves fail-safe output. An interrupt level marks suspect input. A one-cycle log strobe fires once per fail-safe episode and once per silent-mode entry. A saturating counter reports how long the last episode lasted.

Top module: `fsrx_ctrl`

## Requirements
- R1: In normal operation, `rx_out` equals `rx_raw` in the same cycle, and `err_int` and `fs_stat` are both 0.
- R2: While `fs_stat` is 1, `rx_out` is 1 (recessive) whatever value `rx_raw` has.
- R3: A run of consecutive cycles with `bad_in` = 1 that is shorter than `GLITCH_Z` cycles changes neither `err_int` nor `fs_stat` and raises no `log_stb`.
- R4: A run of `bad_in` = 1 moves the block to fault-detected after `GLITCH_Z` cycles, and to fail-safe output (`fs_stat` = 1) in the cycle after the `PERSIST_Y`-th consecutive invalid cycle. The block leaves fail-safe output in the cycle after the `PERSIST_Y`-th consecutive valid cycle. An invalid cycle restarts the valid count.
- R5: `err_int` is 1 in fault-detected and in fail-safe output, and 0 in normal and silent.
- R6: Raising `silent_req` in normal moves the block to silent and raises `log_stb` for exactly one cycle. In silent, `rx_out` still follows `rx_raw`. Dropping `silent_req` returns the block to normal without a strobe.
- R7: Each entry to fail-safe output from fault-detected raises `log_stb` for exactly one cycle, in the first cycle with `fs_stat` = 1. Toggling `bad_in` while in fail-safe output raises no further strobe.
- R8: An invalid run of at least `GLITCH_Z` but fewer than `PERSIST_Y` cycles returns the block to the state it left, normal or silent, in the cycle after the first valid cycle. The return raises no `log_stb`.
- R9: During and after reset the block is in fail-safe output, with `rx_out` = 1, `err_int` = 1 and `dur_cnt` = 0. It reaches normal only after `PERSIST_Y` valid cycles.
- R10: After a fail-safe episode that was entered from fault-detected, `dur_cnt` equals the number of cycles `fs_stat` was 1, saturating at 2^`DUR_W` - 1. It holds that value until the next episode begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_raw | input | 1 | Raw received bit from the transceiver |
| bad_in | input | 1 | 1 when the bus input cannot be trusted |
| silent_req | input | 1 | 1 requests silent (receive-only) operation |
| rx_out | output | 1 | Conditioned received bit for the protocol controller |
| err_int | output | 1 | Fault interrupt level |
| fs_stat | output | 1 | 1 while in fail-safe output |
| log_stb | output | 1 | One-cycle log request strobe |
| dur_cnt | output | DUR_W | Length in cycles of the last fail-safe episode |

## Verification
On every cycle, the bound checker verifies that the output is recessive and the interrupt is held during fail-safe output. It also checks that the interrupt only rises after at least `GLITCH_Z` consecutive invalid cycles, and that fail-safe output is entered and left only after `PERSIST_Y`-long runs. Further checks cover that a log strobe lasts one cycle and marks only a fresh entry, and that the duration counter never falls within an episode. The directed scenarios alone show return to the prior state, including silent, after a short fault. They also show the exact duration value and its saturation, a single strobe across chatter, and the reset exit timing.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
   typedef enum logic [1:0] {
      ST_NORM  = 2'd0,
      ST_SIL   = 2'd1,
      ST_FAULT = 2'd2,
      ST_FS    = 2'd3
   } fsrx_state_e;
endpackage

// File: rtl/fsrx_run.sv
// Saturating run-length counter: length of the current run of 'hit' cycles,
// including the present cycle.
module fsrx_run #(
   parameter int CNT_W = 4,
   parameter int LIMIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   output logic [CNT_W-1:0] len_now
);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

   logic [CNT_W-1:0] run_q;

   always_comb begin
      if (!hit)
         len_now = '0;
      else if (run_q >= LIM_C)
         len_now = LIM_C;
      else
         len_now = run_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= len_now;
   end
endmodule

// File: rtl/fsrx_dur.sv
// Episode duration counter with saturation.
module fsrx_dur #(
   parameter int DUR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stay,
   output logic [DUR_W-1:0] cnt
);
   localparam logic [DUR_W-1:0] MAX_C = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= DUR_W'(1);
      else if (stay && cnt != MAX_C)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fsrx_ctrl.sv
module fsrx_ctrl
   import fsrx_pkg::*;
#(
   parameter int GLITCH_Z  = 3,
   parameter int PERSIST_Y = 8,
   parameter int DUR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_raw,
   input  logic             bad_in,
   input  logic             silent_req,
   output logic             rx_out,
   output logic             err_int,
   output logic             fs_stat,
   output logic             log_stb,
   output logic [DUR_W-1:0] dur_cnt
);
   localparam int CNT_W = $clog2(PERSIST_Y + 1);
   localparam logic [CNT_W-1:0] Z_C = CNT_W'(GLITCH_Z);
   localparam logic [CNT_W-1:0] Y_C = CNT_W'(PERSIST_Y);

   if (GLITCH_Z < 1 || GLITCH_Z >= PERSIST_Y) begin : g_cfg_windows
      $error("fsrx_ctrl: need 1 <= GLITCH_Z < PERSIST_Y");
   end
   if (DUR_W < 2) begin : g_cfg_dur
      $error("fsrx_ctrl: DUR_W must be at least 2");
   end

   // index 0: invalid run, index 1: valid run
   logic [CNT_W-1:0] run_len [2];

   for (genvar g = 0; g < 2; g++) begin : g_run
      logic hit;
      assign hit = (g == 0) ? bad_in : ~bad_in;
      fsrx_run #(.CNT_W(CNT_W), .LIMIT(PERSIST_Y)) run_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (hit),
         .len_now (run_len[g])
      );
   end

   fsrx_state_e state_q, state_d;
   fsrx_state_e prior_q, prior_d;
   logic        stb_q, stb_d;
   logic        fs_start, fs_stay;

   always_comb begin
      state_d  = state_q;
      prior_d  = prior_q;
      stb_d    = 1'b0;
      fs_start = 1'b0;
      fs_stay  = 1'b0;
      unique case (state_q)
         ST_NORM: begin
            if (run_len[0] >= Z_C) begin
               state_d = ST_FAULT;
               prior_d = ST_NORM;
            end else if (silent_req) begin
               state_d = ST_SIL;
               stb_d   = 1'b1;
            end
         end
         ST_SIL: begin
            if (run_len[0] >= Z_C) begin
               state_d = ST_FAULT;
               prior_d = ST_SIL;
            end else if (!silent_req) begin
               state_d = ST_NORM;
            end
         end
         ST_FAULT: begin
            if (run_len[0] >= Y_C) begin
               state_d  = ST_FS;
               stb_d    = 1'b1;
               fs_start = 1'b1;
            end else if (!bad_in) begin
               state_d = prior_q;
            end
         end
         ST_FS: begin
            if (run_len[1] >= Y_C)
               state_d = ST_NORM;
            else
               fs_stay = 1'b1;
         end
         default: state_d = ST_FS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FS;
         prior_q <= ST_NORM;
         stb_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         prior_q <= prior_d;
         stb_q   <= stb_d;
      end
   end

   fsrx_dur #(.DUR_W(DUR_W)) dur_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fs_start),
      .stay  (fs_stay),
      .cnt   (dur_cnt)
   );

   assign fs_stat = (state_q == ST_FS);
   assign err_int = (state_q == ST_FS) || (state_q == ST_FAULT);
   assign rx_out  = fs_stat ? 1'b1 : rx_raw;
   assign log_stb = stb_q;
endmodule

// File: rtl/fsrx_chk.sv
module fsrx_chk #(
   parameter int GLITCH_Z  = 3,
   parameter int PERSIST_Y = 8,
   parameter int DUR_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bad_in,
   input logic             rx_out,
   input logic             err_int,
   input logic             fs_stat,
   input logic             log_stb,
   input logic [DUR_W-1:0] dur_cnt
);
   logic [15:0] bad_seen, good_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_seen  <= '0;
         good_seen <= '0;
      end else begin
         bad_seen  <= bad_in  ? ((bad_seen  == 16'hFFFF) ? bad_seen  : bad_seen  + 16'd1) : 16'd0;
         good_seen <= !bad_in ? ((good_seen == 16'hFFFF) ? good_seen : good_seen + 16'd1) : 16'd0;
      end
   end

   p_safe_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stat |-> rx_out);

   p_err_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stat |-> err_int);

   p_glitch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_int) |-> (bad_seen >= 16'(GLITCH_Z)));

   p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_stat) |-> (bad_seen >= 16'(PERSIST_Y)));

   p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fs_stat) |-> (good_seen >= 16'(PERSIST_Y)));

   p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      log_stb |=> !log_stb);

   p_stb_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (log_stb && fs_stat) |-> !$past(fs_stat));

   p_dur_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_stat && $past(fs_stat)) |-> (dur_cnt >= $past(dur_cnt)));
endmodule

bind fsrx_ctrl fsrx_chk #(
   .GLITCH_Z  (GLITCH_Z),
   .PERSIST_Y (PERSIST_Y),
   .DUR_W     (DUR_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .bad_in  (bad_in),
   .rx_out  (rx_out),
   .err_int (err_int),
   .fs_stat (fs_stat),
   .log_stb (log_stb),
   .dur_cnt (dur_cnt)
);

// File: tb/fsrx_ctrl_tb_top.sv
`timescale 1ns/1ps
module fsrx_ctrl_tb_top;
   localparam int Z  = 3;
   localparam int Y  = 8;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_raw = 1'b1;
   logic bad_in = 1'b0;
   logic silent_req = 1'b0;
   logic rx_out, err_int, fs_stat, log_stb;
   logic [DW-1:0] dur_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   int n_stb   = 0;

   always #10 clk = ~clk;

   fsrx_ctrl #(.GLITCH_Z(Z), .PERSIST_Y(Y), .DUR_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .bad_in(bad_in),
      .silent_req(silent_req), .rx_out(rx_out), .err_int(err_int),
      .fs_stat(fs_stat), .log_stb(log_stb), .dur_cnt(dur_cnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // apply inputs for one clock edge, then sample at the next falling edge
   task automatic step(input logic bad, input logic rx, input logic sil);
      bad_in = bad; rx_raw = rx; silent_req = sil;
      @(negedge clk);
      if (log_stb) n_stb++;
   endtask

   task automatic t_reset();
      chk("R9 reset fs_stat", fs_stat, 1);
      chk("R9 reset rx_out", rx_out, 1);
      chk("R9 reset err_int", err_int, 1);
      chk("R9 reset dur_cnt", dur_cnt, 0);
      chk("R9 reset log_stb", log_stb, 0);
      rst_n = 1'b1;
      for (int i = 1; i < Y; i++) step(1'b0, 1'b0, 1'b0);
      chk("R9 still fail-safe before Y", fs_stat, 1);
      chk("R2 rx recessive in fail-safe", rx_out, 1);
      step(1'b0, 1'b0, 1'b0);
      chk("R9 normal after Y valid", fs_stat, 0);
      chk("R1 err idle in normal", err_int, 0);
      chk("R1 rx follows raw 0", rx_out, 0);
      step(1'b0, 1'b1, 1'b0);
      chk("R1 rx follows raw 1", rx_out, 1);
   endtask

   task automatic t_glitch();
      int s0 = n_stb;
      for (int i = 1; i < Z; i++) begin
         step(1'b1, 1'b0, 1'b0);
         chk("R3 glitch no err", err_int, 0);
      end
      step(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) step(i[0] ? 1'b0 : 1'b1, 1'b0, 1'b0);
      chk("R3 chatter no err", err_int, 0);
      chk("R3 chatter no fs", fs_stat, 0);
      chk("R3 no strobe", n_stb, s0);
      step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_short_fault();
      int s0 = n_stb;
      for (int i = 1; i < Z; i++) step(1'b1, 1'b0, 1'b0);
      chk("R3 err low before Z", err_int, 0);
      step(1'b1, 1'b0, 1'b0);
      chk("R5 err in fault-detected", err_int, 1);
      chk("R4 no fs at Z", fs_stat, 0);
      for (int i = Z + 1; i < Y; i++) step(1'b1, 1'b0, 1'b0);
      chk("R4 no fs at Y-1", fs_stat, 0);
      step(1'b0, 1'b0, 1'b0);
      chk("R8 back to normal err", err_int, 0);
      chk("R8 back to normal rx", rx_out, 0);
      chk("R8 no strobe on return", n_stb, s0);
   endtask

   task automatic t_episode();
      int s0 = n_stb;
      for (int i = 1; i < Y; i++) step(1'b1, 1'b0, 1'b0);
      chk("R4 no fs at Y-1", fs_stat, 0);
      step(1'b1, 1'b0, 1'b0);
      chk("R4 fs after Y invalid", fs_stat, 1);
      chk("R7 strobe on entry", log_stb, 1);
      chk("R2 rx recessive raw 0", rx_out, 1);
      chk("R5 err in fail-safe", err_int, 1);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) step(i[0] ? 1'b1 : 1'b0, 1'b0, 1'b0);
      chk("R4 chatter keeps fs", fs_stat, 1);
      chk("R7 one strobe per episode", n_stb, s0 + 1);
      for (int i = 1; i < Y; i++) step(1'b0, 1'b0, 1'b0);
      chk("R4 fs before Y valid", fs_stat, 1);
      step(1'b0, 1'b0, 1'b0);
      chk("R4 exit after Y valid", fs_stat, 0);
      chk("R10 episode duration", dur_cnt, 25 + Y);
      step(1'b0, 1'b0, 1'b0);
      chk("R10 duration held", dur_cnt, 25 + Y);
   endtask

   task automatic t_silent();
      int s0 = n_stb;
      step(1'b0, 1'b0, 1'b1);
      chk("R6 strobe on silent entry", log_stb, 1);
      chk("R6 silent rx raw 0", rx_out, 0);
      chk("R5 err idle in silent", err_int, 0);
      step(1'b0, 1'b1, 1'b1);
      chk("R6 strobe one cycle", log_stb, 0);
      chk("R6 silent rx raw 1", rx_out, 1);
      for (int i = 0; i < Z; i++) step(1'b1, 1'b0, 1'b1);
      chk("R5 err in fault from silent", err_int, 1);
      step(1'b0, 1'b0, 1'b1);
      chk("R8 err clears", err_int, 0);
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      chk("R8 returned to silent, no re-entry strobe", n_stb, s0 + 1);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R6 leave silent no strobe", n_stb, s0 + 1);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < Y + 300; i++) step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < Y; i++) step(1'b0, 1'b0, 1'b0);
      chk("R10 exit after long episode", fs_stat, 0);
      chk("R10 duration saturates", dur_cnt, (1 << DW) - 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_glitch();
      t_short_fault();
      t_episode();
      t_silent();
      t_saturate();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule